// File: doc/BRIEF.md
# Clock Recovery Retry Controller

This block sequences the clock recovery phase of link training for one hop of a chain of link repeaters. It sends short configuration messages and waits for each one to be acknowledged. It writes the training pattern and the lane drive settings through a register-access port, and it reads back per-lane lock status and the drive adjustments that the far end requests. A microsecond tick input times the wait before each status read.

The block has two modes. In hop-by-hop mode the controller announces the training stage, sends drive levels to the hop just below the tunnel endpoint, and writes lane settings on every attempt. The hop next to the endpoint needs only one acknowledged link message. In transparent mode the controller writes the pattern once and then only polls. Two independent caps bound the retries. One counts all attempts. The other counts consecutive attempts whose requested drive equals the current drive. A sink that keeps alternating its request therefore cannot hold the loop forever.

Top module: `cr_retry_ctrl`

## Requirements
- R1: In hop-by-hop mode with hop equal to the repeater count, exactly one message of type 0x01 is sent, with data bit 0 set and bits 7:1 zero. An acknowledge gives result 0 (success) and no acknowledge gives result 1 (abort). The register port is not used.
- R2: On the first attempt only, hop-by-hop mode first sends message type 0x18 carrying a stage code (pattern select 0,1,2,3 maps to 0x01,0x02,0x03,0x07). Both modes then write the pattern (reg_op 0) with data equal to pattern select plus one.
- R3: Message type 0x19 is sent on every attempt, but only when hop plus one equals the repeater count. Its data carries swing in bits 1:0, swing-at-max (swing==3) in bit 2, pre-emphasis in bits 4:3, pre-emphasis-at-max in bit 5, and zeros in bits 7:6.
- R4: In hop-by-hop mode every attempt writes the lane settings (reg_op 1) using the R3 byte layout. Transparent mode sends no messages and makes no lane-setting writes.
- R5: Before each status read (reg_op 2) the controller waits FIXED_US microsecond ticks in hop-by-hop mode, or wait_us ticks in transparent mode.
- R6: The result is 0 when every active lane reports its rd_cr_ok bit set. Active lanes are lanes 0..lane_cnt-1, where lane_cnt is 1, 2 or 4. Bits of inactive lanes are ignored.
- R7: When some active lane fails, the result is 4 plus the index of the lowest failing active lane.
- R8: An attempt whose lane 0 request (rd_adj[1:0] swing, rd_adj[3:2] pre-emphasis) equals the current drive increments a consecutive counter. Any other attempt clears it. The phase ends with a failure once the counter reaches MAX_SAME.
- R9: The phase ends with a failure after MAX_TOT status reads, even when the requests keep changing.
- R10: A failed read taken while the current swing is already 3 ends the phase at once with a failure.
- R11: A missing acknowledge or a reg_err on any access ends the phase at once with result 1.
- R12: The next drive is the largest swing and the largest pre-emphasis requested over the active lanes (lane i at rd_adj[4i+3:4i]). Pre-emphasis is then reduced so that swing plus pre-emphasis does not exceed 3.
- R13: busy is high from the cycle after start until the result is ready. done is a one-cycle pulse, and result holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a phase (taken only when idle) |
| nontransp | input | 1 | 1 = hop-by-hop mode, 0 = transparent |
| hop | input | HW | Hop being trained, 0 = final receiver |
| rpt_cnt | input | HW | Number of repeaters in the chain |
| lane_cnt | input | 3 | Active lanes: 1, 2 or 4 |
| pat_sel | input | 2 | Recovery pattern select, 0..3 |
| wait_us | input | TW | Transparent-mode read interval in ticks |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| msg_req | output | 1 | Message request, held until msg_done |
| msg_type | output | 8 | Message type |
| msg_data | output | 8 | Message data byte |
| msg_done | input | 1 | Message finished |
| msg_ack | input | 1 | Acknowledge received, valid with msg_done |
| reg_req | output | 1 | Register access request, held until reg_done |
| reg_op | output | 2 | 0 pattern write, 1 lane write, 2 status read |
| reg_hop | output | HW | Hop addressed by the access |
| reg_wdata | output | 8 | Write data |
| reg_done | input | 1 | Access finished |
| reg_err | input | 1 | Access failed, valid with reg_done |
| rd_cr_ok | input | 4 | Per-lane lock status, valid with a read's reg_done |
| rd_adj | input | 16 | Per-lane requested swing and pre-emphasis |
| busy | output | 1 | Phase in progress |
| done | output | 1 | Result ready pulse |
| result | output | 3 | 0 success, 1 abort, 4..7 failing lane |

## Verification
A single status read can satisfy a success condition and an exit condition at the same time. When lock is reported on the read that would push the consecutive counter to its cap, the read is a success. When lock is reported on the read taken right after swing reached its maximum, that read is also a success. The bench builds both cases with scripted sink responses: one keeps lane 0's request at the current drive for four failed reads and then reports lock, and the other requests swing 3 and then reports lock. In both cases the bench expects success together with the exact number of reads.

// File: rtl/cr_retry_ctrl.sv
module cr_retry_ctrl #(
  parameter int HW       = 3,
  parameter int TW       = 16,
  parameter int MAX_SAME = 5,
  parameter int MAX_TOT  = 10,
  parameter int FIXED_US = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          nontransp,
  input  logic [HW-1:0] hop,
  input  logic [HW-1:0] rpt_cnt,
  input  logic [2:0]    lane_cnt,
  input  logic [1:0]    pat_sel,
  input  logic [TW-1:0] wait_us,
  input  logic          us_tick,
  output logic          msg_req,
  output logic [7:0]    msg_type,
  output logic [7:0]    msg_data,
  input  logic          msg_done,
  input  logic          msg_ack,
  output logic          reg_req,
  output logic [1:0]    reg_op,
  output logic [HW-1:0] reg_hop,
  output logic [7:0]    reg_wdata,
  input  logic          reg_done,
  input  logic          reg_err,
  input  logic [3:0]    rd_cr_ok,
  input  logic [15:0]   rd_adj,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result
);
  localparam int SW = $clog2(MAX_SAME + 1);
  localparam int CW = $clog2(MAX_TOT + 1);
  localparam logic [SW-1:0] SAME_LIM = SW'(MAX_SAME);
  localparam logic [CW-1:0] TOT_LIM  = CW'(MAX_TOT);
  localparam logic [2:0] RES_OK = 3'd0, RES_ABORT = 3'd1;

  typedef enum logic [3:0] {S_IDLE, S_LINK, S_TRN, S_PAT, S_VS, S_LANE, S_WAIT, S_READ, S_FIN} st_t;
  st_t st;

  logic          c_nt;
  logic [HW-1:0] c_hop, c_rpt;
  logic [2:0]    c_lanes;
  logic [1:0]    c_pat;
  logic [TW-1:0] c_wait;
  logic [1:0]    sw, pe;
  logic [SW-1:0] same_cnt;
  logic [CW-1:0] tot_cnt;
  logic [TW-1:0] tcnt;
  logic [2:0]    res;

  logic [3:0]    mask;
  logic          all_ok, near_link, near_down, same, cont;
  logic [1:0]    fl, nsw, npe;
  logic [SW-1:0] same_nxt;
  logic [CW-1:0] tot_nxt;
  logic [TW-1:0] ivl;
  logic [7:0]    drv_byte, stage;
  st_t           iter_st;

  assign mask      = (c_lanes == 3'd4) ? 4'hF : (c_lanes == 3'd2) ? 4'h3 : 4'h1;
  assign all_ok    = ((rd_cr_ok | ~mask) == 4'hF);
  assign near_link = (c_hop == c_rpt);
  assign near_down = (({1'b0, c_hop} + (HW+1)'(1)) == {1'b0, c_rpt});
  assign same      = (rd_adj[1:0] == sw) && (rd_adj[3:2] == pe);
  assign same_nxt  = same ? same_cnt + SW'(1) : '0;
  assign tot_nxt   = tot_cnt + CW'(1);
  assign cont      = (same_nxt < SAME_LIM) && (tot_nxt < TOT_LIM);
  assign ivl       = c_nt ? TW'(FIXED_US) : c_wait;
  assign drv_byte  = {2'b00, pe == 2'd3, pe, sw == 2'd3, sw};
  assign stage     = (c_pat == 2'd3) ? 8'h07 : {6'd0, c_pat} + 8'd1;
  assign iter_st   = c_nt ? (near_down ? S_VS : S_LANE) : S_WAIT;

  always_comb begin
    nsw = '0;
    npe = '0;
    fl  = '0;
    for (int i = 0; i < 4; i++) begin
      if (mask[i]) begin
        if (rd_adj[4*i +: 2] > nsw) nsw = rd_adj[4*i +: 2];
        if (rd_adj[4*i+2 +: 2] > npe) npe = rd_adj[4*i+2 +: 2];
      end
    end
    if ({1'b0, nsw} + {1'b0, npe} > 3'd3) npe = 2'd3 - nsw;
    for (int i = 3; i >= 0; i--)
      if (mask[i] && !rd_cr_ok[i]) fl = 2'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      c_nt <= 1'b0; c_hop <= '0; c_rpt <= '0; c_lanes <= 3'd1; c_pat <= '0; c_wait <= '0;
      sw <= '0; pe <= '0; same_cnt <= '0; tot_cnt <= '0; tcnt <= '0; res <= RES_OK;
    end else begin
      tcnt <= (st == S_WAIT) ? tcnt + TW'(us_tick) : '0;
      case (st)
        S_IDLE: if (start) begin
          c_nt <= nontransp; c_hop <= hop; c_rpt <= rpt_cnt; c_lanes <= lane_cnt;
          c_pat <= pat_sel; c_wait <= wait_us;
          sw <= '0; pe <= '0; same_cnt <= '0; tot_cnt <= '0;
          st <= nontransp ? ((hop == rpt_cnt) ? S_LINK : S_TRN) : S_PAT;
        end
        S_LINK: if (msg_done) begin
          res <= msg_ack ? RES_OK : RES_ABORT;
          st  <= S_FIN;
        end
        S_TRN: if (msg_done) begin
          if (msg_ack) st <= S_PAT;
          else begin res <= RES_ABORT; st <= S_FIN; end
        end
        S_PAT: if (reg_done) begin
          if (reg_err) begin res <= RES_ABORT; st <= S_FIN; end
          else st <= iter_st;
        end
        S_VS: if (msg_done) begin
          if (msg_ack) st <= S_LANE;
          else begin res <= RES_ABORT; st <= S_FIN; end
        end
        S_LANE: if (reg_done) begin
          if (reg_err) begin res <= RES_ABORT; st <= S_FIN; end
          else st <= S_WAIT;
        end
        S_WAIT: if (us_tick && (tcnt == ivl - TW'(1))) st <= S_READ;
        S_READ: if (reg_done) begin
          if (reg_err) begin
            res <= RES_ABORT; st <= S_FIN;
          end else if (all_ok) begin
            res <= RES_OK; st <= S_FIN;
          end else if (sw == 2'd3 || !cont) begin
            res <= {1'b1, fl}; st <= S_FIN;
          end else begin
            same_cnt <= same_nxt;
            tot_cnt  <= tot_nxt;
            sw <= nsw;
            pe <= npe;
            st <= iter_st;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign msg_req   = (st == S_LINK) || (st == S_TRN) || (st == S_VS);
  assign msg_type  = (st == S_LINK) ? 8'h01 : (st == S_TRN) ? 8'h18 : (st == S_VS) ? 8'h19 : 8'h00;
  assign msg_data  = (st == S_LINK) ? 8'h01 : (st == S_TRN) ? stage : (st == S_VS) ? drv_byte : 8'h00;
  assign reg_req   = (st == S_PAT) || (st == S_LANE) || (st == S_READ);
  assign reg_op    = (st == S_READ) ? 2'd2 : (st == S_LANE) ? 2'd1 : 2'd0;
  assign reg_hop   = c_hop;
  assign reg_wdata = (st == S_PAT) ? {6'd0, c_pat} + 8'd1 : (st == S_LANE) ? drv_byte : 8'h00;
  assign busy      = (st != S_IDLE) && (st != S_FIN);
  assign done      = (st == S_FIN);
  assign result    = res;
endmodule

module cr_retry_ctrl_chk #(
  parameter int HW       = 3,
  parameter int MAX_SAME = 5,
  parameter int MAX_TOT  = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          msg_req,
  input logic [7:0]    msg_type,
  input logic          reg_req,
  input logic [1:0]    reg_op,
  input logic [7:0]    reg_wdata,
  input logic [$clog2(MAX_SAME+1)-1:0] same_cnt,
  input logic [$clog2(MAX_TOT+1)-1:0]  tot_cnt,
  input logic          c_nt,
  input logic [HW-1:0] c_hop,
  input logic [HW-1:0] c_rpt
);
  // R1
  link_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && c_nt && (c_hop == c_rpt) |-> !reg_req);
  // R4
  transp_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !c_nt |-> !msg_req);
  // R3
  drive_msg_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req && (msg_type == 8'h19) |-> (({1'b0, c_hop} + (HW+1)'(1)) == {1'b0, c_rpt}));
  // R12
  drive_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && (reg_op == 2'd1) |-> ({1'b0, reg_wdata[1:0]} + {1'b0, reg_wdata[4:3]} <= 3'd3));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R8
  same_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(same_cnt) < MAX_SAME));
  // R9
  tot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(tot_cnt) < MAX_TOT));
endmodule

bind cr_retry_ctrl cr_retry_ctrl_chk #(.HW(HW), .MAX_SAME(MAX_SAME), .MAX_TOT(MAX_TOT)) u_chk (.*);

// File: tb/cr_retry_ctrl_test.sv
module cr_retry_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, nontransp = 1'b0, us_tick = 1'b0;
  logic [2:0] hop = '0, rpt_cnt = '0, lane_cnt = 3'd1;
  logic [1:0] pat_sel = '0;
  logic [15:0] wait_us = 16'd1;
  logic msg_done = 1'b0, msg_ack = 1'b0, reg_done = 1'b0, reg_err = 1'b0;
  logic [3:0] rd_cr_ok = '0;
  logic [15:0] rd_adj = '0;
  logic msg_req, reg_req, busy, done;
  logic [7:0] msg_type, msg_data, reg_wdata;
  logic [1:0] reg_op;
  logic [2:0] reg_hop, result;

  int checks = 0, errors = 0, cyc = 0;
  int nmsg, nreg, nread, nlane, npat, ticks, mode, err_at, nack_at;
  logic [7:0] m_type [0:63];
  logic [7:0] m_data [0:63];
  logic [1:0] r_op   [0:63];
  logic [7:0] r_data [0:63];

  cr_retry_ctrl uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void sink(input int m, input int n, output logic [3:0] ok, output logic [15:0] adj);
    ok = 4'h0; adj = 16'h0;
    case (m)
      0: ok = 4'hF;
      1: ok = (n >= 2) ? 4'hF : 4'h0;
      3: adj = (n % 2 == 0) ? 16'h0001 : 16'h0000;
      4: adj = 16'h0003;
      5: ok = 4'b1011;
      6: ok = 4'b0011;
      7: begin ok = (n >= 1) ? 4'hF : 4'h0; adj = (n == 0) ? 16'h03A1 : 16'h0; end
      8: ok = (n >= 4) ? 4'hF : 4'h0;
      9: begin ok = (n >= 1) ? 4'hF : 4'h0; adj = (n == 0) ? 16'h0003 : 16'h0; end
      default: ;
    endcase
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      us_tick = (cyc % 2 == 0);
      if (msg_done) msg_done = 1'b0;
      else if (msg_req) begin
        if (nmsg < 64) begin m_type[nmsg] = msg_type; m_data[nmsg] = msg_data; end
        msg_ack = (nmsg != nack_at);
        msg_done = 1'b1;
        nmsg++;
      end
      if (reg_done) reg_done = 1'b0;
      else if (reg_req) begin
        if (nreg < 64) begin r_op[nreg] = reg_op; r_data[nreg] = reg_wdata; end
        reg_err = (nreg == err_at);
        if (reg_op == 2'd2) begin
          sink(mode, nread, rd_cr_ok, rd_adj);
          nread++;
        end
        if (reg_op == 2'd1) nlane++;
        if (reg_op == 2'd0) npat++;
        reg_done = 1'b1;
        nreg++;
      end
      if (busy && !msg_req && !reg_req && us_tick) ticks++;
    end
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic run(input bit nt, input int h, input int r, input int ln, input int p,
                     input int wt, input int m, input int ea, input int na, output int res);
    int n;
    @(negedge clk);
    nmsg = 0; nreg = 0; nread = 0; nlane = 0; npat = 0; ticks = 0;
    mode = m; err_at = ea; nack_at = na;
    nontransp = nt; hop = 3'(h); rpt_cnt = 3'(r); lane_cnt = 3'(ln);
    pat_sel = 2'(p); wait_us = 16'(wt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R13 busy after start", busy, 1);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R13 done seen", done, 1);
    res = int'(result);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R13 done one cycle", done, 0);
    chk(int'(result) == res, "R13 result held", result, res);
  endtask

  initial begin
    int res;
    nmsg = 0; nreg = 0; nread = 0; nlane = 0; npat = 0; ticks = 0;
    mode = 0; err_at = -1; nack_at = -1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !msg_req && !reg_req && result == 3'd0, "R13 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 endpoint hop, acknowledged
    run(1, 2, 2, 1, 0, 1, 0, -1, -1, res);
    chk(res == 0, "R1 ack success", res, 0);
    chk(nmsg == 1 && m_type[0] == 8'h01 && m_data[0] == 8'h01, "R1 link msg", m_type[0], 1);
    chk(nreg == 0, "R1 no register access", nreg, 0);
    // R1 R11 endpoint hop, no acknowledge
    run(1, 2, 2, 1, 0, 1, 0, -1, 0, res);
    chk(res == 1, "R1 nack abort", res, 1);

    // R2 R3 R4 R5 hop just below endpoint
    run(1, 1, 2, 1, 3, 1, 1, -1, -1, res);
    chk(res == 0 && nread == 3, "R6 success on third read", nread, 3);
    chk(m_type[0] == 8'h18 && m_data[0] == 8'h07, "R2 stage msg", m_data[0], 7);
    chk(r_op[0] == 2'd0 && r_data[0] == 8'd4 && npat == 1, "R2 single pattern write", r_data[0], 4);
    chk(nmsg == 4 && m_type[1] == 8'h19 && m_data[1] == 8'h00, "R3 drive msg per attempt", nmsg, 4);
    chk(nlane == 3, "R4 lane write per attempt", nlane, 3);
    chk(ticks == 300, "R5 fixed interval", ticks, 300);

    // R3 no drive msg on lower hop, R2 stage code for pattern 1
    run(1, 0, 2, 1, 0, 1, 1, -1, -1, res);
    chk(nmsg == 1 && m_data[0] == 8'h01, "R3 no drive msg lower hop", nmsg, 1);
    chk(res == 0, "R6 lower hop success", res, 0);

    // R8 R4 R5 transparent, unchanged requests
    run(0, 0, 0, 1, 1, 7, 2, -1, -1, res);
    chk(res == 4 && nread == 5, "R8 consecutive cap", nread, 5);
    chk(nmsg == 0 && nlane == 0, "R4 transparent no msg or lane write", nmsg + nlane, 0);
    chk(npat == 1 && r_data[0] == 8'd2, "R2 transparent pattern write", r_data[0], 2);
    chk(ticks == 35, "R5 transparent interval", ticks, 35);

    // R9 toggling swing request
    run(1, 0, 1, 1, 0, 1, 3, -1, -1, res);
    chk(res == 4 && nread == 10, "R9 total cap", nread, 10);

    // R10 R3 R12 maximum swing
    run(1, 0, 1, 1, 0, 1, 4, -1, -1, res);
    chk(res == 4 && nread == 2, "R10 max swing exit", nread, 2);
    chk(r_op[3] == 2'd1 && r_data[3] == 8'h07, "R12 lane byte at max swing", r_data[3], 7);
    chk(m_type[2] == 8'h19 && m_data[2] == 8'h07, "R3 drive byte at max swing", m_data[2], 7);

    // R7 failing lane code
    run(0, 0, 0, 4, 0, 3, 5, -1, -1, res);
    chk(res == 6 && nread == 5, "R7 lowest failing lane", res, 6);
    // R6 inactive lanes ignored
    run(0, 0, 0, 2, 0, 3, 6, -1, -1, res);
    chk(res == 0 && nread == 1, "R6 inactive lanes ignored", res, 0);

    // R12 max over active lanes with clip
    run(1, 0, 2, 2, 0, 1, 7, -1, -1, res);
    chk(res == 0 && nread == 2, "R12 run success", nread, 2);
    chk(r_op[3] == 2'd1 && r_data[3] == 8'h0A, "R12 merged drive", r_data[3], 10);

    // R8 corner: lock on the read that reaches the cap
    run(1, 0, 2, 1, 0, 1, 8, -1, -1, res);
    chk(res == 0 && nread == 5, "R8 success wins at cap", res, 0);
    // R10 corner: lock right after max swing
    run(1, 0, 2, 1, 0, 1, 9, -1, -1, res);
    chk(res == 0 && nread == 2, "R10 success wins at max swing", res, 0);

    // R11 aborts
    run(1, 0, 2, 1, 0, 1, 0, 0, -1, res);
    chk(res == 1 && nread == 0, "R11 pattern write error", res, 1);
    run(1, 0, 2, 1, 0, 1, 0, 2, -1, res);
    chk(res == 1 && nread == 1, "R11 read error", res, 1);
    run(1, 0, 2, 1, 0, 1, 0, -1, 0, res);
    chk(res == 1 && nreg == 0, "R11 stage msg nack", res, 1);
    run(1, 0, 1, 1, 0, 1, 0, -1, 1, res);
    chk(res == 1 && nread == 0, "R11 drive msg nack", res, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule